// File: doc/BRIEF.md
# Three-Master, Four-Slave Crossbar Switch

This block sits between three bus masters and four slave ports and lets their transfers proceed side by side. Each master raises a request that carries a 2-bit slave index, a 32-bit address and 64-bit write data. The switch connects the master to that slave. The slave answers with 64-bit read data and a one-cycle completion strobe. When masters target different slaves, all of them are connected at once.

When two or three masters name the same slave, an arbiter that belongs to that slave picks one of them. It rotates through the masters, starting just after the master it granted most recently. The winner keeps the connection until the slave signals completion. Every other contender sees its ready low and waits.

Handshake rules:
- A master asserts `m_valid` and holds its index, address and data steady until its `m_done` pulses.
- `m_ready` high means the master is connected. `m_ready` low means it is stalled, and it must keep requesting.
- A master that leaves `m_valid` high in the cycle after `m_done` is making a new request, and that request enters arbitration again.
- On the slave side, `s_valid` high means a master is connected. The slave completes the transfer by raising `s_done` for one cycle, which may be the same cycle in which `s_valid` first rises.

Top module: `xsw_top`

## Requirements
- R1: While master m is connected to slave s, `s_addr[s]` and `s_wdata[s]` equal master m's address and write data, and `m_rdata[m]` equals `s_rdata[s]`. A slave index value k selects slave port k, for k = 0 to 3.
- R2: Masters that target distinct idle slaves are all connected in the same cycle their requests appear. No master is ever connected to two slaves.
- R3: A slave is connected to at most one master at a time, and only to a master that is requesting it.
- R4: From the cycle a master is connected until the cycle its slave raises `s_done`, inclusive, that connection does not change. Other requesters of the slave keep `m_ready` low during that time.
- R5: The cycle after `s_done`, the slave is free and is granted again from the requests present in that cycle.
- R6: Each new grant goes to the first requesting master found in the order last+1, last+2, and so on, modulo 3, where last is the master that slave granted most recently. After reset, last is master 2, so master 0 has first claim.
- R7: Each slave keeps its own last-granted record. The record changes only when that slave issues a new grant.
- R8: `m_done[m]` pulses only while master m is connected, and it follows its slave's `s_done`. `s_valid[s]` is high only while slave s is connected.
- R9: A master that keeps requesting a slave is connected before that slave has granted any two other masters in a row.
- R10: When `s_done` arrives in the same cycle the grant is issued, the transfer ends in that cycle, and the following cycle is arbitrated anew.
- R11: After reset, no master is connected and no slave sees a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_valid | input | 3 | Request strobe per master |
| m_ready | output | 3 | Master connected to its slave |
| m_sel | input | 3x2 | Target slave index per master |
| m_addr | input | 3x32 | Address per master |
| m_wdata | input | 3x64 | Write data per master |
| m_rdata | output | 3x64 | Read data returned to each master |
| m_done | output | 3 | Completion pulse per master |
| s_valid | output | 4 | Request presented to each slave |
| s_addr | output | 4x32 | Address routed to each slave |
| s_wdata | output | 4x64 | Write data routed to each slave |
| s_rdata | input | 4x64 | Read data from each slave |
| s_done | input | 4 | Completion pulse from each slave |

## Verification
Some properties are checked by assertions on every cycle:
- each slave has at most one owner, and that owner is a current requester;
- no master is wired to two slaves;
- a grant stays frozen until completion;
- a slave's last-granted record does not move while it is busy.

Other behaviours only the directed scenarios can show. These are the rotation order across repeated collisions, the bound on waiting, the independence of the per-slave records, the same-cycle completion case, and the exact routing of address, write data and read data.

// File: rtl/xsw_pkg.sv
`timescale 1ns/1ps
package xsw_pkg;
  localparam int unsigned XSW_MASTERS = 3;
  localparam int unsigned XSW_SLAVES  = 4;
  localparam int unsigned XSW_ADDR_W  = 32;
  localparam int unsigned XSW_DATA_W  = 64;
endpackage

// File: rtl/xsw_decode.sv
`timescale 1ns/1ps
module xsw_decode #(
  parameter int unsigned NM = 3,
  parameter int unsigned NS = 4,
  parameter int unsigned SW = 2
) (
  input  logic [NM-1:0]         m_valid,
  input  logic [NM-1:0][SW-1:0] m_sel,
  output logic [NS-1:0][NM-1:0] req
);
  // Request matrix: row = slave, column = master.
  for (genvar s = 0; s < NS; s++) begin : g_slv
    for (genvar m = 0; m < NM; m++) begin : g_mst
      assign req[s][m] = m_valid[m] && (m_sel[m] == SW'(s));
    end
  end
endmodule

// File: rtl/xsw_slot_arb.sv
`timescale 1ns/1ps
module xsw_slot_arb #(
  parameter int unsigned NM = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NM-1:0] req,
  input  logic          done,
  output logic [NM-1:0] gnt
);
  localparam int unsigned IW = (NM > 1) ? $clog2(NM) : 1;

  logic          busy_q;
  logic [NM-1:0] own_q;
  logic [IW-1:0] last_q;
  logic [NM-1:0] pick;
  logic [IW-1:0] pick_idx;
  logic          pick_any;

  // Rotating search starting just after the last granted master.
  always_comb begin
    int cand;
    pick     = '0;
    pick_idx = last_q;
    pick_any = 1'b0;
    for (int k = 1; k <= int'(NM); k++) begin
      cand = (int'(last_q) + k) % int'(NM);
      if (!pick_any && req[cand]) begin
        pick_any       = 1'b1;
        pick_idx       = IW'(cand);
        pick[cand]     = 1'b1;
      end
    end
  end

  assign gnt = busy_q ? own_q : pick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      own_q  <= '0;
      last_q <= IW'(NM - 1);
    end else if (busy_q) begin
      if (done) begin
        busy_q <= 1'b0;
        own_q  <= '0;
      end
    end else if (pick_any) begin
      last_q <= pick_idx;
      if (!done) begin
        busy_q <= 1'b1;
        own_q  <= pick;
      end
    end
  end

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R3
  AST_OWNER_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0); // R3
  AST_GRANT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt) && !done) |=> (gnt == $past(gnt))); // R4
  AST_PTR_STILL_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(last_q)); // R7
endmodule

// File: rtl/xsw_route.sv
`timescale 1ns/1ps
module xsw_route #(
  parameter int unsigned NM = 3,
  parameter int unsigned NS = 4,
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NS-1:0][NM-1:0] gnt,
  input  logic [NM-1:0][AW-1:0] m_addr,
  input  logic [NM-1:0][DW-1:0] m_wdata,
  input  logic [NS-1:0][DW-1:0] s_rdata,
  input  logic [NS-1:0]         s_done,
  output logic [NM-1:0]         m_ready,
  output logic [NM-1:0][DW-1:0] m_rdata,
  output logic [NM-1:0]         m_done,
  output logic [NS-1:0]         s_valid,
  output logic [NS-1:0][AW-1:0] s_addr,
  output logic [NS-1:0][DW-1:0] s_wdata
);
  // AND-OR multiplexing over one-hot grants in both directions.
  always_comb begin
    m_ready = '0;
    m_rdata = '0;
    m_done  = '0;
    s_valid = '0;
    s_addr  = '0;
    s_wdata = '0;
    for (int s = 0; s < int'(NS); s++) begin
      for (int m = 0; m < int'(NM); m++) begin
        if (gnt[s][m]) begin
          s_valid[s] = 1'b1;
          s_addr[s]  = s_addr[s]  | m_addr[m];
          s_wdata[s] = s_wdata[s] | m_wdata[m];
          m_ready[m] = 1'b1;
          m_rdata[m] = m_rdata[m] | s_rdata[s];
          m_done[m]  = m_done[m]  | s_done[s];
        end
      end
    end
  end

  for (genvar m = 0; m < NM; m++) begin : g_col
    logic [NS-1:0] col;
    for (genvar s = 0; s < NS; s++) begin : g_bit
      assign col[s] = gnt[s][m];
    end
    AST_ONE_SLAVE_PER_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(col) <= 1); // R2
  end
endmodule

// File: rtl/xsw_top.sv
`timescale 1ns/1ps
module xsw_top
  import xsw_pkg::*;
#(
  parameter int unsigned NM = XSW_MASTERS,
  parameter int unsigned NS = XSW_SLAVES,
  parameter int unsigned AW = XSW_ADDR_W,
  parameter int unsigned DW = XSW_DATA_W,
  localparam int unsigned SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NM-1:0]         m_valid,
  output logic [NM-1:0]         m_ready,
  input  logic [NM-1:0][SW-1:0] m_sel,
  input  logic [NM-1:0][AW-1:0] m_addr,
  input  logic [NM-1:0][DW-1:0] m_wdata,
  output logic [NM-1:0][DW-1:0] m_rdata,
  output logic [NM-1:0]         m_done,
  output logic [NS-1:0]         s_valid,
  output logic [NS-1:0][AW-1:0] s_addr,
  output logic [NS-1:0][DW-1:0] s_wdata,
  input  logic [NS-1:0][DW-1:0] s_rdata,
  input  logic [NS-1:0]         s_done
);
  logic [NS-1:0][NM-1:0] req;
  logic [NS-1:0][NM-1:0] gnt;

  xsw_decode #(.NM(NM), .NS(NS), .SW(SW)) u_decode (
    .m_valid (m_valid),
    .m_sel   (m_sel),
    .req     (req)
  );

  for (genvar s = 0; s < NS; s++) begin : g_arb
    xsw_slot_arb #(.NM(NM)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req[s]),
      .done  (s_done[s]),
      .gnt   (gnt[s])
    );
  end

  xsw_route #(.NM(NM), .NS(NS), .AW(AW), .DW(DW)) u_route (
    .clk     (clk),
    .rst_n   (rst_n),
    .gnt     (gnt),
    .m_addr  (m_addr),
    .m_wdata (m_wdata),
    .s_rdata (s_rdata),
    .s_done  (s_done),
    .m_ready (m_ready),
    .m_rdata (m_rdata),
    .m_done  (m_done),
    .s_valid (s_valid),
    .s_addr  (s_addr),
    .s_wdata (s_wdata)
  );

  AST_DONE_ONLY_CONNECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (m_done & ~m_ready) == '0); // R8
endmodule

// File: tb/xsw_top_tb.sv
`timescale 1ns/1ps
module xsw_top_tb;
  localparam int NM = 3;
  localparam int NS = 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NM-1:0]        m_valid = '0;
  logic [NM-1:0]        m_ready;
  logic [NM-1:0][1:0]   m_sel = '0;
  logic [NM-1:0][31:0]  m_addr;
  logic [NM-1:0][63:0]  m_wdata;
  logic [NM-1:0][63:0]  m_rdata;
  logic [NM-1:0]        m_done;
  logic [NS-1:0]        s_valid;
  logic [NS-1:0][31:0]  s_addr;
  logic [NS-1:0][63:0]  s_wdata;
  logic [NS-1:0][63:0]  s_rdata;
  logic [NS-1:0]        s_done = '0;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  xsw_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .m_valid(m_valid), .m_ready(m_ready), .m_sel(m_sel),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_done(m_done),
    .s_valid(s_valid), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_rdata(s_rdata), .s_done(s_done)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk("R11 ready after reset", 64'(m_ready), 64'h0);
    chk("R11 s_valid after reset", 64'(s_valid), 64'h0);
  endtask

  // Three masters on three different slaves at once.
  task automatic t_parallel();
    m_sel[0] = 2'd2; m_sel[1] = 2'd0; m_sel[2] = 2'd3;
    m_valid = 3'b111;
    #1;
    chk("R2 all connected same cycle", 64'(m_ready), 64'h7);
    chk("R8 s_valid pattern", 64'(s_valid), 64'hD);
    chk("R1 addr m0->s2", 64'(s_addr[2]), 64'(m_addr[0]));
    chk("R1 wdata m1->s0", s_wdata[0], m_wdata[1]);
    chk("R1 rdata s3->m2", m_rdata[2], s_rdata[3]);
    chk("R8 no done yet", 64'(m_done), 64'h0);
    s_done[2] = 1'b1;
    #1;
    chk("R8 done follows slave 2", 64'(m_done), 64'h1);
    tick();
    s_done = '0; m_valid[0] = 1'b0;
    #1;
    chk("R4 others held", 64'(m_ready), 64'h6);
    s_done[0] = 1'b1; s_done[3] = 1'b1;
    tick();
    s_done = '0; m_valid = '0;
    #1;
    chk("R5 idle after done", 64'(s_valid), 64'h0);
  endtask

  // All three on slave 1; rotation starts at master 0 after reset.
  task automatic t_collide();
    m_sel[0] = 2'd1; m_sel[1] = 2'd1; m_sel[2] = 2'd1;
    m_valid = 3'b111;
    #1;
    chk("R6 first winner m0", 64'(m_ready), 64'h1);
    chk("R1 s1 addr from m0", 64'(s_addr[1]), 64'(m_addr[0]));
    for (int c = 0; c < 3; c++) begin
      tick();
      #1;
      chk("R4 grant held", 64'(m_ready), 64'h1);
    end
    s_done[1] = 1'b1;
    #1;
    chk("R8 only winner sees done", 64'(m_done), 64'h1);
    tick();
    s_done = '0; m_valid[0] = 1'b0;
    #1;
    chk("R5 rearbitrated to m1", 64'(m_ready), 64'h2);
    chk("R1 s1 wdata from m1", s_wdata[1], m_wdata[1]);
    chk("R1 m1 rdata from s1", m_rdata[1], s_rdata[1]);
    s_done[1] = 1'b1;
    tick();
    s_done = '0; m_valid[1] = 1'b0;
    #1;
    chk("R6 then m2", 64'(m_ready), 64'h4);
    s_done[1] = 1'b1;
    tick();
    s_done = '0; m_valid = '0;
    #1;
    chk("R5 slave 1 free", 64'(s_valid), 64'h0);
  endtask

  // Masters keep requesting slave 1; grants must rotate 0,1,2,0,1,2.
  task automatic t_fair();
    int since [NM];
    for (int m = 0; m < NM; m++) since[m] = 0;
    m_sel[0] = 2'd1; m_sel[1] = 2'd1; m_sel[2] = 2'd1;
    m_valid = 3'b111;
    for (int g = 0; g < 6; g++) begin
      #1;
      chk("R6 rotation order", 64'(m_ready), 64'(3'b001 << (g % 3)));
      for (int m = 0; m < NM; m++) begin
        if (m_ready[m]) begin
          chk("R9 waited at most two grants", 64'(since[m] <= 2), 64'h1);
          since[m] = 0;
        end else begin
          since[m]++;
        end
      end
      tick();
      #1;
      chk("R4 held one more cycle", 64'(m_ready), 64'(3'b001 << (g % 3)));
      s_done[1] = 1'b1;
      tick();
      s_done = '0;
    end
    m_valid = '0;
    #1;
  endtask

  // Done in the grant cycle: no hold, next cycle rearbitrates.
  task automatic t_single();
    m_sel[1] = 2'd3; m_sel[2] = 2'd3;
    m_valid = 3'b110;
    s_done[3] = 1'b1;
    #1;
    chk("R10 m1 wins s3", 64'(m_ready), 64'h2);
    chk("R10 done same cycle", 64'(m_done), 64'h2);
    tick();
    s_done = '0; m_valid[1] = 1'b0;
    #1;
    chk("R10 m2 next cycle", 64'(m_ready), 64'h4);
    s_done[3] = 1'b1;
    tick();
    s_done = '0; m_valid = '0;
    #1;
  endtask

  // Slave 0 last granted m1, slave 1 last granted m2: same requests, own pointer.
  task automatic t_independent();
    m_sel[0] = 2'd0; m_sel[2] = 2'd0;
    m_valid = 3'b101;
    #1;
    chk("R7 slave 0 uses own record", 64'(m_ready), 64'h4);
    s_done[0] = 1'b1;
    tick();
    s_done = '0; m_valid = '0;
    m_sel[0] = 2'd1; m_sel[2] = 2'd1;
    m_valid = 3'b101;
    #1;
    chk("R7 slave 1 uses own record", 64'(m_ready), 64'h1);
    s_done[1] = 1'b1;
    tick();
    s_done = '0; m_valid = '0;
    #1;
    chk("R3 nothing connected at end", 64'(s_valid), 64'h0);
  endtask

  initial begin
    for (int m = 0; m < NM; m++) begin
      m_addr[m]  = 32'hA000_0000 + 32'(m * 16);
      m_wdata[m] = {32'hC0DE_0000 + 32'(m), 32'h1234_5670 + 32'(m)};
    end
    for (int s = 0; s < NS; s++) s_rdata[s] = {32'hF00D_0000 + 32'(s), 32'h5A5A_0000 + 32'(s)};
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_parallel();
    tick();
    t_collide();
    tick();
    t_fair();
    tick();
    t_single();
    tick();
    t_independent();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule